// File: doc/BRIEF.md
# Carry-Free Signed-Digit Modular Adder

This block adds two residues that are held as p-digit radix-2 signed-digit words and returns their sum, reduced modulo m, in the same signed-digit form. Each digit is one of −1, 0 or +1 and travels on two wires: a positive plane and a negative plane. The modulus is fixed at elaboration time and is one of 2^p − 1, 2^p + 1 or 2^p.

The adder has no carry chain. Every digit position splits its local sum into a transfer to the next position and an interim digit. The choice depends only on the position just below it, so no final digit can overflow. The transfer that leaves the top position is folded back into digit 0 in the same single stage. For 2^p − 1 it keeps its sign, for 2^p + 1 its sign is inverted, and for 2^p it is dropped. Because of this, the delay is the same for any p. The block is purely combinational and holds no state. The result is a valid residue, but it is not normalised to a unique binary value.

Top module: `sd_mod_adder`

## Requirements
- R1: With the modulus set to 2^p − 1, the integer value of the result (digit i weighs 2^i, digit value = pos − neg) is congruent to the sum of the operand values modulo 2^p − 1.
- R2: With the modulus set to 2^p + 1, the result value is congruent to the sum of the operand values modulo 2^p + 1.
- R3: With the modulus set to 2^p, the result value is congruent to the sum of the operand values modulo 2^p.
- R4: For operands whose digits are all legal, no result digit ever has both its positive and negative bits set. The encoding is (0,0) = 0, (1,0) = +1, (0,1) = −1, and (1,1) is illegal.
- R5: Two all-zero operands give an all-zero result.
- R6: Two operands with every digit at +1 give a correct residue in every modulus mode.
- R7: Two operands with every digit at −1 give a correct residue in every modulus mode.
- R8: An operand added to its digit-wise negation gives a result congruent to 0.
- R9: The result depends only on the present operands. The same operands give the same result digits, whatever operands came before them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opAPos | input | P | Positive plane of operand A, one bit per digit |
| opANeg | input | P | Negative plane of operand A |
| opBPos | input | P | Positive plane of operand B |
| opBNeg | input | P | Negative plane of operand B |
| sumPos | output | P | Positive plane of the modular sum |
| sumNeg | output | P | Negative plane of the modular sum |

## Verification
The same operand patterns are applied to one instance of each modulus mode, so the three wraparound rules can be told apart directly. All-zero operands show that no spurious transfer appears. All +1 and all −1 operands push a transfer out of every position, including the top, so they expose a missing or wrongly signed wrap into digit 0. Random legal operands cover the mixed cases where the look-at-lower-position rule must pick the transfer correctly. A value plus its negation, and replayed operands, check cancellation and the absence of stored state.

// File: rtl/sdmod_pkg.sv
package sdmod_pkg;

  typedef enum logic [1:0] {
    MOD_POW2   = 2'd0,
    MOD_MINUS1 = 2'd1,
    MOD_PLUS1  = 2'd2
  } modSel_e;

  typedef struct packed {
    logic pos;
    logic neg;
  } sdDigit_t;

  // strobes from the mode control to the datapath
  typedef struct packed {
    logic wrapEn;   // feed top transfer back into digit 0
    logic wrapNeg;  // invert its sign on the way
  } wrapCtl_t;

  function automatic logic signed [2:0] digitVal(sdDigit_t d);
    logic signed [2:0] v;
    v = 3'sd0;
    if (d.pos && !d.neg) v = 3'sd1;
    else if (d.neg && !d.pos) v = -3'sd1;
    return v;
  endfunction

  function automatic sdDigit_t digitEnc(logic signed [2:0] v);
    sdDigit_t d;
    d.pos = (v > 3'sd0);
    d.neg = (v < 3'sd0);
    return d;
  endfunction

endpackage

// File: rtl/sd_digit_cell.sv
module sd_digit_cell
  import sdmod_pkg::*;
(
  input  sdDigit_t xDig,
  input  sdDigit_t yDig,
  input  logic     lowNonNeg,
  output sdDigit_t transferDig,
  output sdDigit_t interimDig
);

  logic signed [2:0] localSum;
  logic signed [2:0] tVal;
  logic signed [2:0] wVal;

  always_comb begin
    localSum = digitVal(xDig) + digitVal(yDig);
    tVal = 3'sd0;
    wVal = 3'sd0;
    case (localSum)
      3'sd2:  begin tVal = 3'sd1;  wVal = 3'sd0; end
      -3'sd2: begin tVal = -3'sd1; wVal = 3'sd0; end
      3'sd1: begin
        if (lowNonNeg) begin tVal = 3'sd1; wVal = -3'sd1; end
        else           begin tVal = 3'sd0; wVal = 3'sd1;  end
      end
      -3'sd1: begin
        if (lowNonNeg) begin tVal = 3'sd0;  wVal = -3'sd1; end
        else           begin tVal = -3'sd1; wVal = 3'sd1;  end
      end
      default: begin tVal = 3'sd0; wVal = 3'sd0; end
    endcase
    transferDig = digitEnc(tVal);
    interimDig  = digitEnc(wVal);
  end

  // R4: the interim digit leans away from the transfer that may arrive from below
  always_comb begin
    p_interim_lean_r4: assert (lowNonNeg ? (digitVal(interimDig) <= 3'sd0)
                                         : (digitVal(interimDig) >= 3'sd0))
      else $error("interim digit leans the wrong way");
  end

endmodule

// File: rtl/sd_mod_ctrl.sv
module sd_mod_ctrl
  import sdmod_pkg::*;
#(
  parameter modSel_e MODE = MOD_MINUS1
) (
  output wrapCtl_t ctl
);

  always_comb begin
    ctl.wrapEn  = (MODE != MOD_POW2);
    ctl.wrapNeg = (MODE == MOD_PLUS1);
  end

endmodule

// File: rtl/sd_mod_datapath.sv
module sd_mod_datapath
  import sdmod_pkg::*;
#(
  parameter int P = 8
) (
  input  logic [P-1:0] aPos,
  input  logic [P-1:0] aNeg,
  input  logic [P-1:0] bPos,
  input  logic [P-1:0] bNeg,
  input  wrapCtl_t     ctl,
  output logic [P-1:0] sPos,
  output logic [P-1:0] sNeg
);

  localparam int TOP = P - 1;

  logic [P-1:0] lowNonNeg;
  sdDigit_t     transferArr [P];
  sdDigit_t     interimArr  [P];
  logic signed [2:0] incoming [P];
  logic signed [2:0] digitSum [P];

  always_comb begin
    if (!ctl.wrapEn)      lowNonNeg[0] = 1'b1;
    else if (ctl.wrapNeg) lowNonNeg[0] = !aPos[TOP] && !bPos[TOP];
    else                  lowNonNeg[0] = !aNeg[TOP] && !bNeg[TOP];
    for (int i = 1; i < P; i++) begin
      lowNonNeg[i] = !aNeg[i-1] && !bNeg[i-1];
    end
  end

  generate
    for (genvar g = 0; g < P; g++) begin : gCell
      sd_digit_cell cell_i (
        .xDig       ('{pos: aPos[g], neg: aNeg[g]}),
        .yDig       ('{pos: bPos[g], neg: bNeg[g]}),
        .lowNonNeg  (lowNonNeg[g]),
        .transferDig(transferArr[g]),
        .interimDig (interimArr[g])
      );
    end
  endgenerate

  always_comb begin
    if (!ctl.wrapEn)      incoming[0] = 3'sd0;
    else if (ctl.wrapNeg) incoming[0] = -digitVal(transferArr[TOP]);
    else                  incoming[0] = digitVal(transferArr[TOP]);
    for (int i = 1; i < P; i++) begin
      incoming[i] = digitVal(transferArr[i-1]);
    end
    for (int i = 0; i < P; i++) begin
      digitSum[i] = digitVal(interimArr[i]) + incoming[i];
      sPos[i] = (digitSum[i] > 3'sd0);
      sNeg[i] = (digitSum[i] < 3'sd0);
    end
  end

  // R4: interim plus incoming transfer stays a single signed digit
  always_comb begin
    for (int i = 0; i < P; i++) begin
      p_no_overflow_r4: assert (digitSum[i] <= 3'sd1 && digitSum[i] >= -3'sd1)
        else $error("digit %0d overflowed", i);
    end
  end

endmodule

// File: rtl/sd_mod_adder.sv
module sd_mod_adder
  import sdmod_pkg::*;
#(
  parameter int      P    = 8,
  parameter modSel_e MODE = MOD_MINUS1
) (
  input  logic [P-1:0] opAPos,
  input  logic [P-1:0] opANeg,
  input  logic [P-1:0] opBPos,
  input  logic [P-1:0] opBNeg,
  output logic [P-1:0] sumPos,
  output logic [P-1:0] sumNeg
);

  localparam longint BASE    = longint'(64'(1) << P);
  localparam longint MODULUS = (MODE == MOD_POW2)   ? BASE :
                               (MODE == MOD_MINUS1) ? BASE - 1 : BASE + 1;

  wrapCtl_t ctl;

  sd_mod_ctrl #(.MODE(MODE)) ctrl_i (
    .ctl(ctl)
  );

  sd_mod_datapath #(.P(P)) dp_i (
    .aPos(opAPos),
    .aNeg(opANeg),
    .bPos(opBPos),
    .bNeg(opBNeg),
    .ctl (ctl),
    .sPos(sumPos),
    .sNeg(sumNeg)
  );

  function automatic longint wordVal(logic [P-1:0] pv, logic [P-1:0] nv);
    longint acc;
    acc = 0;
    for (int k = 0; k < P; k++) begin
      if (pv[k] && !nv[k]) acc = acc + (longint'(1) <<< k);
      if (nv[k] && !pv[k]) acc = acc - (longint'(1) <<< k);
    end
    return acc;
  endfunction

  longint diffVal;

  // R1 R2 R3: result congruent to the operand sum in the selected modulus
  // R5: zero in gives zero out; R4: result digits legal
  always_comb begin
    diffVal = wordVal(sumPos, sumNeg) - wordVal(opAPos, opANeg) - wordVal(opBPos, opBNeg);
    if (((opAPos & opANeg) == '0) && ((opBPos & opBNeg) == '0)) begin
      p_residue_r1: assert ((diffVal % MODULUS) == 0)
        else $error("sum not congruent");
      p_legal_out_r4: assert ((sumPos & sumNeg) == '0)
        else $error("illegal result digit");
    end
    if ((opAPos | opANeg | opBPos | opBNeg) == '0) begin
      p_zero_r5: assert ((sumPos | sumNeg) == '0)
        else $error("zero operands gave nonzero sum");
    end
  end

endmodule

// File: tb/sd_mod_adder_tb_top.sv
module sd_mod_adder_tb_top;
  import sdmod_pkg::*;

  localparam int P = 8;
  localparam int MP1 = (1 << P) - 1;
  localparam int MQ1 = (1 << P) + 1;
  localparam int MP2 = (1 << P);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;   // 250 MHz

  logic [P-1:0] aPos = '0, aNeg = '0, bPos = '0, bNeg = '0;
  logic [P-1:0] m1Pos, m1Neg, p1Pos, p1Neg, pwPos, pwNeg;

  int checkCnt = 0;
  int failCnt  = 0;

  sd_mod_adder #(.P(P), .MODE(MOD_MINUS1)) dut_i (
    .opAPos(aPos), .opANeg(aNeg), .opBPos(bPos), .opBNeg(bNeg),
    .sumPos(m1Pos), .sumNeg(m1Neg));
  sd_mod_adder #(.P(P), .MODE(MOD_PLUS1)) dutPlus_i (
    .opAPos(aPos), .opANeg(aNeg), .opBPos(bPos), .opBNeg(bNeg),
    .sumPos(p1Pos), .sumNeg(p1Neg));
  sd_mod_adder #(.P(P), .MODE(MOD_POW2)) dutPow_i (
    .opAPos(aPos), .opANeg(aNeg), .opBPos(bPos), .opBNeg(bNeg),
    .sumPos(pwPos), .sumNeg(pwNeg));

  function automatic int sdv(logic [P-1:0] pv, logic [P-1:0] nv);
    int acc = 0;
    for (int k = 0; k < P; k++) begin
      if (pv[k]) acc += (1 << k);
      if (nv[k]) acc -= (1 << k);
    end
    return acc;
  endfunction

  function automatic int modR(int v, int m);
    return ((v % m) + m) % m;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic applyOps(logic [P-1:0] ap, logic [P-1:0] an,
                          logic [P-1:0] bp, logic [P-1:0] bn);
    @(negedge clk);
    aPos = ap; aNeg = an; bPos = bp; bNeg = bn;
    @(posedge clk);
    #1;
  endtask

  // checks all three moduli plus digit legality for the present operands
  task automatic checkAll(string scen);
    int s = sdv(aPos, aNeg) + sdv(bPos, bNeg);
    check(modR(sdv(m1Pos, m1Neg), MP1) == modR(s, MP1), "R1", scen,
          modR(sdv(m1Pos, m1Neg), MP1), modR(s, MP1));
    check(modR(sdv(p1Pos, p1Neg), MQ1) == modR(s, MQ1), "R2", scen,
          modR(sdv(p1Pos, p1Neg), MQ1), modR(s, MQ1));
    check(modR(sdv(pwPos, pwNeg), MP2) == modR(s, MP2), "R3", scen,
          modR(sdv(pwPos, pwNeg), MP2), modR(s, MP2));
    check(((m1Pos & m1Neg) | (p1Pos & p1Neg) | (pwPos & pwNeg)) == '0, "R4", scen,
          int'((m1Pos & m1Neg) | (p1Pos & p1Neg) | (pwPos & pwNeg)), 0);
  endtask

  task automatic testReset();
    // R5: zero operands during and after reset
    check((m1Pos | m1Neg | p1Pos | p1Neg | pwPos | pwNeg) == '0, "R5", "reset zero",
          int'(m1Pos | m1Neg | p1Pos | p1Neg | pwPos | pwNeg), 0);
    applyOps('0, '0, '0, '0);
    check((m1Pos | m1Neg | p1Pos | p1Neg | pwPos | pwNeg) == '0, "R5", "zero operands",
          int'(m1Pos | m1Neg | p1Pos | p1Neg | pwPos | pwNeg), 0);
  endtask

  task automatic testAllPlus();
    applyOps('1, '0, '1, '0);
    checkAll("R6 all plus one");
  endtask

  task automatic testAllMinus();
    applyOps('0, '1, '0, '1);
    checkAll("R7 all minus one");
    applyOps('1, '0, '0, '1);
    checkAll("R7 plus and minus words");
  endtask

  task automatic testRandom();
    for (int n = 0; n < 60; n++) begin
      logic [P-1:0] ap, an, bp, bn;
      ap = P'($urandom); an = P'($urandom) & ~ap;
      bp = P'($urandom); bn = P'($urandom) & ~bp;
      applyOps(ap, an, bp, bn);
      checkAll("R1 R2 R3 random");
    end
  endtask

  task automatic testNegate();
    for (int n = 0; n < 10; n++) begin
      logic [P-1:0] ap, an;
      ap = P'($urandom); an = P'($urandom) & ~ap;
      applyOps(ap, an, an, ap);
      check(modR(sdv(m1Pos, m1Neg), MP1) == 0, "R8", "negation mod 2^p-1",
            modR(sdv(m1Pos, m1Neg), MP1), 0);
      check(modR(sdv(p1Pos, p1Neg), MQ1) == 0, "R8", "negation mod 2^p+1",
            modR(sdv(p1Pos, p1Neg), MQ1), 0);
      check(modR(sdv(pwPos, pwNeg), MP2) == 0, "R8", "negation mod 2^p",
            modR(sdv(pwPos, pwNeg), MP2), 0);
    end
  endtask

  task automatic testMemoryless();
    logic [P-1:0] firstPos, firstNeg;
    applyOps(8'h5A, 8'h21, 8'h0F, 8'hC0);
    firstPos = p1Pos; firstNeg = p1Neg;
    applyOps('0, '1, '1, '0);
    applyOps(8'h5A, 8'h21, 8'h0F, 8'hC0);
    check(p1Pos == firstPos && p1Neg == firstNeg, "R9", "replayed operands",
          int'({p1Pos, p1Neg}), int'({firstPos, firstNeg}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failCnt++;
    checkCnt++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    testReset();
    rst = 1'b0;
    testAllPlus();
    testAllMinus();
    testRandom();
    testNegate();
    testMemoryless();
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule